// File: doc/BRIEF.md
# Hot-Plug Interrupt Aggregator

This block gathers the interrupt sources of a hot-plug slot controller into one level interrupt line and one system-error line. Each slot's register bank gives a pending flag and an error request for that slot. The command engine pulses when a command finishes, and the bus arbiter pulses when it detects an error. These sources are combined into a read-only locator word and a writable control/status word.

The control/status word holds four mask bits and two sticky detect bits. Software clears a detect bit by writing 1 to it. A global interrupt mask silences the interrupt output but does not discard any pending state. This lets a host mask the line, read the locator to find the sources, service them, clear the detects, and then unmask. If any source is still pending when the mask is cleared, the line rises again.

Top module: `hp_irq_agg`

## Requirements
- R1: Locator bit i+1 reads as the pending flag of slot i. Locator bits above NUM_SLOTS read as 0.
- R2: Locator bit 0 reads 1 only when the command-complete detect (control bit 16) is set and the command interrupt mask (control bit 2) is 0.
- R3: A cmd_done pulse sets control bit 16, and the bit stays set until a control write has 1 in bit 16. A write with 0 in that bit leaves it set. When a pulse and a clearing write arrive in the same cycle, the bit ends up set.
- R4: An arb_err pulse sets control bit 17, and the bit stays set until a control write has 1 in bit 17. A write with 0 in that bit leaves it set.
- R5: Control bits 15:4 and 31:18 read as 0 whatever is written to them. Writes with reg_sel=0 (the locator) change neither word.
- R6: After reset, the control word reads 0x0000000F: all four masks are 1 and both detects are 0. The locator reads 0 while no slot is pending, and both outputs are 0.
- R7: irq_o is 1 when the global interrupt mask (control bit 0) is 0 and the locator is nonzero. It follows the inputs one clock edge after they change.
- R8: serr_o is 1 when the global error mask (control bit 1) is 0 and at least one of these holds: any slot_serr bit is 1, or the arbiter detect is set while the arbiter error mask (control bit 3) is 0. serr_o is registered like irq_o.
- R9: Setting the global interrupt mask changes neither the detect bits nor the locator. Clearing the mask again raises irq_o if sources are still pending.
- R10: A control write loads wdata[3:0] into the four mask bits, and they read back at the same positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 locator word, 1 control/status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word chosen by reg_sel (combinational) |
| slot_pend | input | NUM_SLOTS | Per-slot interrupt pending flags |
| slot_serr | input | NUM_SLOTS | Per-slot system-error requests |
| cmd_done | input | 1 | Command-complete pulse |
| arb_err | input | 1 | Arbiter-error pulse |
| irq_o | output | 1 | Level interrupt output |
| serr_o | output | 1 | System-error output |

## Verification
The hardest case to reach is a cmd_done pulse that lands in the same cycle as a write clearing that detect. Only the set-wins rule separates a correct design from one that loses the completion. The bench drives the pulse and the clearing write on the same falling edge, so both are sampled by the same rising edge. It then reads the control word. It also walks the full mask/unmask cycle with a detect still pending, to show that the line comes back once the global mask is removed.

// File: rtl/hp_irq_pkg.sv
package hp_irq_pkg;
    localparam int MASK_W    = 4;
    localparam int GMASK_BIT = 0;
    localparam int GSERR_BIT = 1;
    localparam int CMASK_BIT = 2;
    localparam int AMASK_BIT = 3;
    localparam int CDET_BIT  = 16;
    localparam int ADET_BIT  = 17;

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              cmd_det;
        logic              arb_det;
    } ctl_state_t;
endpackage

// File: rtl/hp_irq_ctl.sv
module hp_irq_ctl
    import hp_irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic        cmd_done,
    input  logic        arb_err,
    output ctl_state_t  st_d,
    output ctl_state_t  st_q
);
    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mask = wdata[MASK_W-1:0];
            if (wdata[CDET_BIT]) st_d.cmd_det = 1'b0;
            if (wdata[ADET_BIT]) st_d.arb_det = 1'b0;
        end
        // a new event outranks a clear in the same cycle
        if (cmd_done) st_d.cmd_det = 1'b1;
        if (arb_err)  st_d.arb_det = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mask    <= '1;
            st_q.cmd_det <= 1'b0;
            st_q.arb_det <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/hp_irq_locator.sv
module hp_irq_locator
    import hp_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int LOC_W    = NUM_SLOTS + 1
) (
    input  logic [NUM_SLOTS-1:0] slot_pend,
    input  ctl_state_t           st,
    output logic [LOC_W-1:0]     loc
);
    assign loc[0] = st.cmd_det & ~st.mask[CMASK_BIT];
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        assign loc[i+1] = slot_pend[i];
    end
endmodule

// File: rtl/hp_irq_out.sv
module hp_irq_out
    import hp_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    localparam int LOC_W    = NUM_SLOTS + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ctl_state_t           st_d,
    input  logic [LOC_W-1:0]     loc_d,
    input  logic [NUM_SLOTS-1:0] slot_serr,
    output logic                 irq_o,
    output logic                 serr_o
);
    typedef struct packed {
        logic irq;
        logic serr;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d.irq  = ~st_d.mask[GMASK_BIT] & (|loc_d);
        o_d.serr = ~st_d.mask[GSERR_BIT] &
                   ((st_d.arb_det & ~st_d.mask[AMASK_BIT]) | (|slot_serr));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign irq_o  = o_q.irq;
    assign serr_o = o_q.serr;
endmodule

// File: rtl/hp_irq_agg.sv
module hp_irq_agg
    import hp_irq_pkg::*;
#(
    parameter int NUM_SLOTS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_sel,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    input  logic [NUM_SLOTS-1:0] slot_pend,
    input  logic [NUM_SLOTS-1:0] slot_serr,
    input  logic                 cmd_done,
    input  logic                 arb_err,
    output logic                 irq_o,
    output logic                 serr_o
);
    localparam int LOC_W = NUM_SLOTS + 1;

    ctl_state_t       ctl_d, ctl_q;
    logic [LOC_W-1:0] loc_now, loc_nxt;
    logic [31:0]      ctl_word;

    hp_irq_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr & reg_sel), .wdata(reg_wdata),
        .cmd_done(cmd_done), .arb_err(arb_err), .st_d(ctl_d), .st_q(ctl_q)
    );

    hp_irq_locator #(.NUM_SLOTS(NUM_SLOTS)) u_loc_now (
        .slot_pend(slot_pend), .st(ctl_q), .loc(loc_now)
    );

    hp_irq_locator #(.NUM_SLOTS(NUM_SLOTS)) u_loc_nxt (
        .slot_pend(slot_pend), .st(ctl_d), .loc(loc_nxt)
    );

    hp_irq_out #(.NUM_SLOTS(NUM_SLOTS)) u_out (
        .clk(clk), .rst_n(rst_n), .st_d(ctl_d), .loc_d(loc_nxt),
        .slot_serr(slot_serr), .irq_o(irq_o), .serr_o(serr_o)
    );

    always_comb begin
        ctl_word = '0;
        ctl_word[MASK_W-1:0] = ctl_q.mask;
        ctl_word[CDET_BIT]   = ctl_q.cmd_det;
        ctl_word[ADET_BIT]   = ctl_q.arb_det;
    end

    assign reg_rdata = reg_sel ? ctl_word : 32'(loc_now);
endmodule

// File: rtl/hp_irq_agg_chk.sv
module hp_irq_agg_chk
    import hp_irq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        reg_wr,
    input logic        reg_sel,
    input logic [31:0] reg_wdata,
    input logic        cmd_done,
    input logic        arb_err,
    input logic        irq_o,
    input logic        serr_o,
    input ctl_state_t  st
);
    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R3
    cmd_det_sets_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(cmd_done) |-> st.cmd_det);
    // R3
    cmd_det_holds_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(st.cmd_det && !(reg_wr && reg_sel && reg_wdata[CDET_BIT])) |-> st.cmd_det);
    // R3
    cmd_det_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $rose(st.cmd_det) |-> $past(cmd_done));
    // R4
    arb_det_holds_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(st.arb_det && !(reg_wr && reg_sel && reg_wdata[ADET_BIT])) |-> st.arb_det);
    // R4
    arb_det_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $rose(st.arb_det) |-> $past(arb_err));
    // R7
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !st.mask[GMASK_BIT]);
    // R8
    serr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        serr_o |-> !st.mask[GSERR_BIT]);
endmodule

bind hp_irq_agg hp_irq_agg_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cmd_done(cmd_done), .arb_err(arb_err),
    .irq_o(irq_o), .serr_o(serr_o), .st(ctl_q)
);

// File: tb/sim_hp_irq_agg.sv
module sim_hp_irq_agg;
    localparam int NS = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NS-1:0] slot_pend = '0;
    logic [NS-1:0] slot_serr = '0;
    logic          cmd_done = 1'b0;
    logic          arb_err = 1'b0;
    logic          irq_o, serr_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hp_irq_agg #(.NUM_SLOTS(NS)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .slot_pend(slot_pend),
        .slot_serr(slot_serr), .cmd_done(cmd_done), .arb_err(arb_err),
        .irq_o(irq_o), .serr_o(serr_o)
    );

    // {mask[3:0], slot_pend, slot_serr, exp_irq, exp_serr}
    localparam logic [21:0] VEC [8] = '{
        {4'b0000, 8'h00, 8'h00, 1'b0, 1'b0},
        {4'b0000, 8'h01, 8'h00, 1'b1, 1'b0},
        {4'b0001, 8'h80, 8'h00, 1'b0, 1'b0},
        {4'b0000, 8'h80, 8'h04, 1'b1, 1'b1},
        {4'b0010, 8'h00, 8'h04, 1'b0, 1'b0},
        {4'b1110, 8'h10, 8'h01, 1'b1, 1'b0},
        {4'b1111, 8'hff, 8'hff, 1'b0, 1'b0},
        {4'b0000, 8'h00, 8'h80, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] d);
        reg_sel = sel;
        #1;
        d = reg_rdata;
    endtask

    task automatic pulse_cmd();
        @(negedge clk); cmd_done = 1'b1;
        @(negedge clk); cmd_done = 1'b0;
    endtask

    task automatic pulse_arb();
        @(negedge clk); arb_err = 1'b1;
        @(negedge clk); arb_err = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R6 reset state
        rd(1'b1, v); chk("R6 ctrl reset", v, 32'h0000000F);
        rd(1'b0, v); chk("R6 locator reset", v, 32'h0);
        chk("R6 irq reset", {31'b0, irq_o}, 32'h0);
        chk("R6 serr reset", {31'b0, serr_o}, 32'h0);
        rst_n = 1'b1;

        // vector walk: R1 R7 R8 R10
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            slot_pend = VEC[i][17:10];
            slot_serr = VEC[i][9:2];
            reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = {28'b0, VEC[i][21:18]};
            @(negedge clk);
            reg_wr = 1'b0; reg_wdata = '0;
            chk("R7 irq vector", {31'b0, irq_o}, {31'b0, VEC[i][1]});
            chk("R8 serr vector", {31'b0, serr_o}, {31'b0, VEC[i][0]});
            rd(1'b0, v); chk("R1 locator vector", v, {23'b0, VEC[i][17:10], 1'b0});
            rd(1'b1, v); chk("R10 mask readback", v, {28'b0, VEC[i][21:18]});
        end
        slot_pend = '0; slot_serr = '0;

        // R2 R3 command detect
        wr(1'b1, 32'h0);
        pulse_cmd();
        rd(1'b1, v); chk("R3 cmd detect set", v, 32'h00010000);
        rd(1'b0, v); chk("R2 locator cmd bit", v, 32'h1);
        chk("R7 irq on cmd", {31'b0, irq_o}, 32'h1);
        wr(1'b1, 32'h0);
        rd(1'b1, v); chk("R3 write0 keeps detect", v, 32'h00010000);

        // R9 global mask keeps state
        wr(1'b1, 32'h1);
        chk("R9 irq masked", {31'b0, irq_o}, 32'h0);
        rd(1'b0, v); chk("R9 locator kept", v, 32'h1);
        rd(1'b1, v); chk("R9 detect kept", v, 32'h00010001);
        wr(1'b1, 32'h0);
        chk("R9 irq returns", {31'b0, irq_o}, 32'h1);

        // R2 command mask hides locator bit
        wr(1'b1, 32'h4);
        rd(1'b0, v); chk("R2 cmd masked locator", v, 32'h0);
        chk("R2 irq with cmd masked", {31'b0, irq_o}, 32'h0);
        rd(1'b1, v); chk("R2 detect still set", v, 32'h00010004);

        // R3 clear by write 1
        wr(1'b1, 32'h00010000);
        rd(1'b1, v); chk("R3 cleared", v, 32'h0);
        chk("R3 irq after clear", {31'b0, irq_o}, 32'h0);

        // R3 set wins over simultaneous clear
        @(negedge clk);
        cmd_done = 1'b1; reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 32'h00010000;
        @(negedge clk);
        cmd_done = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        rd(1'b1, v); chk("R3 set wins", v, 32'h00010000);
        wr(1'b1, 32'h00010000);

        // R4 R8 arbiter detect
        pulse_arb();
        rd(1'b1, v); chk("R4 arb detect set", v, 32'h00020000);
        chk("R8 serr on arb", {31'b0, serr_o}, 32'h1);
        wr(1'b1, 32'h8);
        chk("R8 arb masked", {31'b0, serr_o}, 32'h0);
        rd(1'b1, v); chk("R4 arb kept", v, 32'h00020008);
        wr(1'b1, 32'h2);
        chk("R8 global serr mask", {31'b0, serr_o}, 32'h0);
        wr(1'b1, 32'h00020000);
        rd(1'b1, v); chk("R4 arb cleared", v, 32'h0);

        // R5 reserved bits and locator writes
        wr(1'b1, 32'hFFFCFFF5);
        rd(1'b1, v); chk("R5 reserved read zero", v, 32'h00000005);
        pulse_cmd();
        wr(1'b0, 32'hFFFFFFFF);
        rd(1'b1, v); chk("R5 locator write ignored ctrl", v, 32'h00010005);
        rd(1'b0, v); chk("R5 locator unchanged", v, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule